// File: doc/BRIEF.md
# Two-Pass Grayscale Image Normalizer

This block rescales the grey levels of an 8-bit image held in memory so that the result has a chosen mean and a chosen spread. The image's structure is untouched: every pixel moves away from, or toward, a new centre level by an amount proportional to its distance from the measured centre. Brighter pixels stay brighter and darker pixels stay darker.

Software sets the target mean and target variance, then pulses `start`. In the first pass the block reads every pixel once and accumulates the sum and the sum of squares. A single sequential divider then forms the integer mean, the mean of squares and the variance ratio. A small iterative square-root unit turns that ratio into an unsigned Q8.8 gain, once per image. In the second pass each pixel is read again and mapped with one multiply. The result is written to an output buffer at the same index. `done` pulses when the last write is acknowledged. The memory port is word-addressed with one pixel per word. Reads address the source image and writes address the output buffer, and both start at index 0. The default image holds 76800 pixels (0x12C00 words).

Top module: `image_normalizer`

## Requirements
- R1: While `rst` is high, and after it, until a start is seen, `mem_req` and `done` are 0.
- R2: After `start` in idle, the block issues reads (`mem_we`=0) to addresses 0, 1, … PIX_COUNT-1 in order. After the gain is ready, it issues a second read sweep that begins at address 0.
- R3: Only one memory transfer is open at a time. While `mem_req` is high and no `mem_rvalid`/`mem_wack` has come, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R4: The statistics are computed with truncating integer arithmetic:
  - M = floor(S/N) and V = floor(Q/N) − M², where V is clamped to 0 if the difference is negative.
  - The gain is g = floor(sqrt(floor(tgt_var·65536 / max(V,1)))) and is treated as a Q8.8 value.
- R5: For a pixel I > M, the written value is min(255, M0 + floor(g·(I−M)/256)), where M0 = `tgt_mean`.
- R6: For a pixel I ≤ M, the written value is max(0, M0 − floor(g·(M−I)/256)).
- R7: Second-pass writes (`mem_we`=1) go to output addresses 0 … PIX_COUNT-1 in order. Each write carries the mapped value of the pixel read from the same address.
- R8: `done` is high for exactly one cycle, in the cycle after the last write is acknowledged. No request is made while `done` is high.
- R9: A `start` pulse while an image is in progress is ignored. The run continues with exactly 2·N reads, N writes and one `done` pulse.
- R10: An image whose pixels are all equal (V = 0) is written out with every pixel equal to `tgt_mean`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin normalizing one image (accepted only in idle) |
| tgt_mean | input | 8 | Target mean M0 |
| tgt_var | input | 16 | Target variance |
| mem_req | output | 1 | Memory transfer request, held until acknowledged |
| mem_we | output | 1 | 1 = write to output buffer, 0 = read from source image |
| mem_addr | output | ADDR_W | Pixel word address |
| mem_wdata | output | 8 | Normalized pixel to write |
| mem_rdata | input | 8 | Read pixel, valid with `mem_rvalid` |
| mem_rvalid | input | 1 | Read completes this cycle |
| mem_wack | input | 1 | Write completes this cycle |
| done | output | 1 | One-cycle pulse at the end of an image |

## Verification
A linear ramp exercises both branches of the mapping with gains below and above unity. It separates an error in the mean, the variance or the gain from an error in the branch choice. An image of alternating black and white pixels with a large target variance drives both saturation limits. A flat image checks the zero-variance guard. A narrow, low-contrast image produces a large gain and exposes truncation in the divider and square root. One run receives a second `start` midway, which shows whether the sweep restarts. Every run uses a memory model with varying response latency, so any address or data that changes before its acknowledge is detected.

// File: rtl/norm_pkg.sv
package norm_pkg;
    localparam int PIX_W    = 8;
    localparam int VAR_W    = 16;
    localparam int GAIN_W   = 16;
    localparam int GAIN_FRC = 8;
    localparam int RATIO_W  = VAR_W + 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD1,
        ST_DMEAN,
        ST_DSQ,
        ST_VAR,
        ST_DGAIN,
        ST_SQRT,
        ST_RD2,
        ST_WR2,
        ST_DONE
    } norm_state_e;

    typedef struct packed {
        logic [PIX_W-1:0]  mean;
        logic [2*PIX_W-1:0] msq;
        logic [2*PIX_W-1:0] var_q;
        logic [GAIN_W-1:0] gain;
    } norm_stats_t;
endpackage

// File: rtl/norm_div.sv
module norm_div #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         fin,
    output logic [W-1:0] quot
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem;
    logic [W-1:0]  q;
    logic [W-1:0]  dvs;
    logic [CW-1:0] cnt;
    logic          busy;
    logic [W:0]    shifted;

    assign shifted = {rem[W-1:0], q[W-1]};
    assign quot    = q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem  <= '0;
            q    <= '0;
            dvs  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem  <= '0;
                q    <= dividend;
                dvs  <= divisor;
                cnt  <= CW'(W);
                busy <= 1'b1;
            end else if (busy) begin
                if (shifted >= {1'b0, dvs}) begin
                    rem <= shifted - {1'b0, dvs};
                    q   <= {q[W-2:0], 1'b1};
                end else begin
                    rem <= shifted;
                    q   <= {q[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/norm_isqrt.sv
module norm_isqrt #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic [W-1:0]   radicand,
    output logic           fin,
    output logic [W/2-1:0] root
);
    localparam int STEPS = W / 2;
    localparam int CW    = $clog2(STEPS + 1);

    logic [W-1:0]  op;
    logic [W-1:0]  res;
    logic [W-1:0]  one;
    logic [W-1:0]  trial;
    logic [CW-1:0] cnt;
    logic          busy;

    assign trial = res + one;
    assign root  = res[W/2-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            op   <= '0;
            res  <= '0;
            one  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                op   <= radicand;
                res  <= '0;
                one  <= {2'b01, {(W-2){1'b0}}};
                cnt  <= CW'(STEPS);
                busy <= 1'b1;
            end else if (busy) begin
                if (op >= trial) begin
                    op  <= op - trial;
                    res <= (res >> 1) + one;
                end else begin
                    res <= res >> 1;
                end
                one <= one >> 2;
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/norm_map.sv
module norm_map
    import norm_pkg::*;
(
    input  logic [PIX_W-1:0]  pix,
    input  logic [PIX_W-1:0]  mean,
    input  logic [PIX_W-1:0]  tmean,
    input  logic [GAIN_W-1:0] gain,
    output logic [PIX_W-1:0]  y
);
    localparam int PROD_W = GAIN_W + PIX_W;
    localparam int SC_W   = PROD_W - GAIN_FRC;

    logic               above;
    logic [PIX_W-1:0]   dev;
    logic [PROD_W-1:0]  prod;
    logic [SC_W-1:0]    scaled;
    logic [SC_W:0]      up_sum;

    always_comb begin
        above  = pix > mean;
        dev    = above ? pix - mean : mean - pix;
        prod   = PROD_W'(gain) * PROD_W'(dev);
        scaled = prod[PROD_W-1:GAIN_FRC];
        up_sum = (SC_W+1)'(tmean) + (SC_W+1)'(scaled);
        if (above) begin
            y = (up_sum > (SC_W+1)'(255)) ? 8'hFF : up_sum[PIX_W-1:0];
        end else begin
            y = (SC_W'(tmean) >= scaled) ? tmean - scaled[PIX_W-1:0] : 8'h00;
        end
    end
endmodule

// File: rtl/image_normalizer.sv
module image_normalizer
    import norm_pkg::*;
#(
    parameter int PIX_COUNT = 76800,
    parameter int ADDR_W    = $clog2(PIX_COUNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PIX_W-1:0]  tgt_mean,
    input  logic [VAR_W-1:0]  tgt_var,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_wdata,
    input  logic [PIX_W-1:0]  mem_rdata,
    input  logic              mem_rvalid,
    input  logic              mem_wack,
    output logic              done
);
    localparam int SUM_W = ADDR_W + PIX_W;
    localparam int SQ_W  = ADDR_W + 2 * PIX_W;
    localparam int DIV_W = (SQ_W > RATIO_W) ? SQ_W : RATIO_W;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(PIX_COUNT - 1);

    norm_state_e       state;
    logic [ADDR_W-1:0] addr;
    logic [SUM_W-1:0]  sum;
    logic [SQ_W-1:0]   sqsum;
    norm_stats_t       st;
    logic [PIX_W-1:0]  pix;
    logic              div_go, sq_go, div_fin, sq_fin;
    logic [DIV_W-1:0]  div_a, div_b, div_q;
    logic [GAIN_W-1:0] root;
    logic [2*PIX_W-1:0] mean_sq;

    assign mean_sq = (2*PIX_W)'(st.mean) * (2*PIX_W)'(st.mean);

    always_comb begin
        div_a = DIV_W'(sum);
        div_b = DIV_W'(PIX_COUNT);
        if (state == ST_DSQ) begin
            div_a = DIV_W'(sqsum);
        end else if (state == ST_DGAIN) begin
            div_a = DIV_W'({tgt_var, 16'h0000});
            div_b = (st.var_q == '0) ? DIV_W'(1) : DIV_W'(st.var_q);
        end
    end

    norm_div #(.W(DIV_W)) div_i (
        .clk(clk), .rst(rst), .go(div_go),
        .dividend(div_a), .divisor(div_b),
        .fin(div_fin), .quot(div_q)
    );

    norm_isqrt #(.W(RATIO_W)) sqrt_i (
        .clk(clk), .rst(rst), .go(sq_go),
        .radicand(div_q[RATIO_W-1:0]),
        .fin(sq_fin), .root(root)
    );

    norm_map map_i (
        .pix(pix), .mean(st.mean), .tmean(tgt_mean),
        .gain(st.gain), .y(mem_wdata)
    );

    assign mem_req  = (state == ST_RD1) || (state == ST_RD2) || (state == ST_WR2);
    assign mem_we   = (state == ST_WR2);
    assign mem_addr = addr;
    assign done     = (state == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            addr   <= '0;
            sum    <= '0;
            sqsum  <= '0;
            st     <= '0;
            pix    <= '0;
            div_go <= 1'b0;
            sq_go  <= 1'b0;
        end else begin
            div_go <= 1'b0;
            sq_go  <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RD1;
                    addr  <= '0;
                    sum   <= '0;
                    sqsum <= '0;
                end
                ST_RD1: if (mem_rvalid) begin
                    sum   <= sum + SUM_W'(mem_rdata);
                    sqsum <= sqsum + SQ_W'((2*PIX_W)'(mem_rdata) * (2*PIX_W)'(mem_rdata));
                    if (addr == LAST) begin
                        addr   <= '0;
                        state  <= ST_DMEAN;
                        div_go <= 1'b1;
                    end else begin
                        addr <= addr + 1'b1;
                    end
                end
                ST_DMEAN: if (div_fin) begin
                    st.mean <= div_q[PIX_W-1:0];
                    state   <= ST_DSQ;
                    div_go  <= 1'b1;
                end
                ST_DSQ: if (div_fin) begin
                    st.msq <= div_q[2*PIX_W-1:0];
                    state  <= ST_VAR;
                end
                ST_VAR: begin
                    st.var_q <= (st.msq >= mean_sq) ? st.msq - mean_sq : '0;
                    state    <= ST_DGAIN;
                    div_go   <= 1'b1;
                end
                ST_DGAIN: if (div_fin) begin
                    state <= ST_SQRT;
                    sq_go <= 1'b1;
                end
                ST_SQRT: if (sq_fin) begin
                    st.gain <= root;
                    state   <= ST_RD2;
                end
                ST_RD2: if (mem_rvalid) begin
                    pix   <= mem_rdata;
                    state <= ST_WR2;
                end
                ST_WR2: if (mem_wack) begin
                    if (addr == LAST) begin
                        addr  <= '0;
                        state <= ST_DONE;
                    end else begin
                        addr  <= addr + 1'b1;
                        state <= ST_RD2;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/norm_chk.sv
module norm_chk #(
    parameter int PIX_COUNT = 76800,
    parameter int ADDR_W    = $clog2(PIX_COUNT)
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              mem_rvalid,
    input logic              mem_wack,
    input logic              done
);
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid && !mem_wack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R3
    wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !mem_wack) |=> $stable(mem_wdata));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);

    // R2
    sweep_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> (!mem_we && mem_addr == '0));

    // R7
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (32'(mem_addr) < PIX_COUNT));
endmodule

bind image_normalizer norm_chk #(.PIX_COUNT(PIX_COUNT), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_wack(mem_wack), .done(done)
);

// File: tb/image_normalizer_tb_top.sv
module image_normalizer_tb_top;
    localparam int N  = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [7:0]    tgt_mean = '0;
    logic [15:0]   tgt_var = '0;
    logic          mem_req, mem_we, done;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;
    logic          mem_rvalid = 1'b0;
    logic          mem_wack = 1'b0;

    logic [7:0] img  [N];
    logic [7:0] oimg [N];

    int checks = 0;
    int failures = 0;
    int rd_exp = 0, wr_exp = 0;
    int n_rd = 0, n_wr = 0, n_done = 0;
    int rd_order_err = 0, wr_order_err = 0;
    int dly = 0;
    logic [7:0] lfsr = 8'h5A;
    bit finished = 0;

    always #4 clk = ~clk;

    image_normalizer #(.PIX_COUNT(N), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .tgt_mean(tgt_mean), .tgt_var(tgt_var),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .mem_wack(mem_wack), .done(done)
    );

    // memory model with variable latency
    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (done) n_done <= n_done + 1;
        if (mem_req && !mem_rvalid && !mem_wack) begin
            if (dly == 0) begin
                dly <= int'(lfsr % 3);
                if (mem_we) begin
                    mem_wack <= 1'b1;
                    oimg[mem_addr] <= mem_wdata;
                    if (int'(mem_addr) != wr_exp) wr_order_err <= wr_order_err + 1;
                    wr_exp <= (wr_exp + 1) % N;
                    n_wr <= n_wr + 1;
                end else begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= img[mem_addr];
                    if (int'(mem_addr) != rd_exp) rd_order_err <= rd_order_err + 1;
                    rd_exp <= (rd_exp + 1) % N;
                    n_rd <= n_rd + 1;
                end
            end else begin
                dly <= dly - 1;
            end
        end else begin
            mem_rvalid <= 1'b0;
            mem_wack   <= 1'b0;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint isqrt(input longint r);
        longint g = 0;
        while ((g + 1) * (g + 1) <= r) g++;
        return g;
    endfunction

    task automatic run_image(input string name, input bit restart_mid);
        longint s = 0, q = 0, m, mq, v, g, dv, sc, e;
        int t = 0;
        rd_exp = 0; wr_exp = 0; n_rd = 0; n_wr = 0; n_done = 0;
        rd_order_err = 0; wr_order_err = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
            if (restart_mid && t == 20) start = 1'b1;
            if (restart_mid && t == 21) start = 1'b0;
        end
        chk({name, " R8 done within limit"}, t < 5000, 1);
        @(negedge clk);
        chk({name, " R8 done single pulse"}, n_done, 1);
        chk({name, " R8 idle after done"}, mem_req, 0);
        chk({name, " R2 read order"}, rd_order_err, 0);
        chk({name, " R7 write order"}, wr_order_err, 0);
        chk({name, " R2 read count"}, n_rd, 2 * N);
        chk({name, " R7 write count"}, n_wr, N);
        for (int i = 0; i < N; i++) begin
            s += img[i];
            q += img[i] * img[i];
        end
        m  = s / N;
        mq = q / N;
        v  = (mq >= m * m) ? mq - m * m : 0;
        dv = (v == 0) ? 1 : v;
        g  = isqrt((longint'(tgt_var) * 65536) / dv);   // R4
        for (int i = 0; i < N; i++) begin
            if (img[i] > m) begin
                sc = (g * (img[i] - m)) / 256;
                e = tgt_mean + sc;
                if (e > 255) e = 255;
                chk($sformatf("%s R5 pixel %0d", name, i), oimg[i], e);
            end else begin
                sc = (g * (m - img[i])) / 256;
                e = tgt_mean - sc;
                if (e < 0) e = 0;
                chk($sformatf("%s R6 pixel %0d", name, i), oimg[i], e);
            end
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 req in reset", mem_req, 0);
        chk("R1 done in reset", done, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 req idle after reset", mem_req, 0);
        chk("R1 done idle after reset", done, 0);
    endtask

    task automatic t_ramp();
        for (int i = 0; i < N; i++) img[i] = 8'(i * 16);
        tgt_mean = 8'd100; tgt_var = 16'd400;
        run_image("ramp", 0);
        tgt_var = 16'd20000;
        run_image("ramp_wide R4", 0);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < N; i++) img[i] = (i % 2 == 0) ? 8'd255 : 8'd0;
        tgt_mean = 8'd128; tgt_var = 16'hFFFF;
        run_image("saturate", 0);
        chk("R5 saturate high", oimg[0], 255);
        chk("R6 saturate low", oimg[1], 0);
    endtask

    task automatic t_uniform();
        for (int i = 0; i < N; i++) img[i] = 8'd77;
        tgt_mean = 8'd50; tgt_var = 16'd1000;
        run_image("uniform", 0);
        for (int i = 0; i < N; i++) chk($sformatf("R10 flat pixel %0d", i), oimg[i], 50);
    endtask

    task automatic t_lowcontrast();
        for (int i = 0; i < N; i++) img[i] = 8'(118 + (i % 4));
        tgt_mean = 8'd140; tgt_var = 16'd2000;
        run_image("lowcontrast R4", 0);
    endtask

    task automatic t_restart();
        for (int i = 0; i < N; i++) img[i] = 8'((i * 37 + 11) % 256);
        tgt_mean = 8'd90; tgt_var = 16'd3000;
        run_image("restart R9", 1);
    endtask

    initial begin
        t_reset();
        t_ramp();
        t_saturate();
        t_uniform();
        t_lowcontrast();
        t_restart();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule